// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block performs single write transactions on an 8080-style parallel LCD bus. A core-side agent offers an address and a data word with a valid/ready handshake. The sequencer then steps through four timed phases, all counted in cycles of the video clock that runs the block.

The first phase drives the address with chip select high. In the second, chip select is low and the write strobe is still high. In the third, the write strobe is low and data is on the bus. In the last, the strobe is high again and chip select is still low.

Each phase length comes from its own 4-bit setting and lasts that setting plus one cycle. All four settings are captured when a request is accepted. The chip-select and write-strobe outputs are active low, idle high, and come straight from flip-flops, so they do not glitch.

Top module: `lcd_wr_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_cs_n` and `bus_we_n` are 1, `req_ready` is 1, `busy` is 0 and `bus_data` is 0.
- R2: A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` is 0 and `busy` is 1 until the cycle in which `bus_cs_n` returns to 1.
- R3: From the cycle after acceptance, `bus_addr` equals the accepted address and stays steady for the whole transaction. `bus_cs_n` stays 1 for `cfg_addr_setup`+1 cycles, then goes to 0.
- R4: After `bus_cs_n` goes to 0, `bus_we_n` stays 1 for `cfg_cs_to_we`+1 cycles, then goes to 0.
- R5: `bus_we_n` stays 0 for `cfg_we_width`+1 cycles, then returns to 1.
- R6: After `bus_we_n` returns to 1, `bus_cs_n` stays 0 for `cfg_we_to_cs`+1 cycles, then returns to 1. `req_ready` returns to 1 in the same cycle.
- R7: `bus_data` equals the accepted data word from the cycle in which `bus_we_n` falls until the last cycle in which `bus_cs_n` is 0. At all other times it is 0.
- R8: `bus_we_n` is 0 only while `bus_cs_n` is 0.
- R9: The four timing settings are sampled at acceptance. Changing them during a transaction does not alter that transaction's phase lengths.
- R10: A request offered while `req_ready` is 1 after a finished write is accepted at the next edge. That transaction starts again with the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| req_addr | input | ADDR_W | Address of the requested write |
| req_data | input | DATA_W | Data of the requested write |
| cfg_addr_setup | input | 4 | Address-to-chip-select setup, cycles minus one |
| cfg_cs_to_we | input | 4 | Chip-select-to-strobe setup, cycles minus one |
| cfg_we_width | input | 4 | Strobe low width, cycles minus one |
| cfg_we_to_cs | input | 4 | Strobe-release-to-chip-select-release hold, cycles minus one |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_data | output | DATA_W | Bus write data |
| busy | output | 1 | Transaction in progress |

## Verification
Four timing patterns are run:
- All settings at zero gives the shortest cycle and shows that every phase is at least one cycle long.
- All settings at fifteen shows that the counters reach full range without wrapping.
- The ascending setting 1,2,3,4 and the descending setting 4,3,2,1 give each phase a distinct length, so a setting routed to the wrong phase changes an edge position.

The settings are changed in the middle of a write to show that they are captured at acceptance. Writes are then issued back to back to check the restart from the address phase. A reset in the middle of a write must return the bus pins to idle.

// File: rtl/lcd_wr_seq_pkg.sv
package lcd_wr_seq_pkg;
    localparam int TIME_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_CSSET = 3'd2,
        PH_STRB  = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [TIME_W-1:0] addr_setup;
        logic [TIME_W-1:0] cs_to_we;
        logic [TIME_W-1:0] we_width;
        logic [TIME_W-1:0] we_to_cs;
    } timing_t;
endpackage

// File: rtl/lcd_wr_seq_timer.sv
module lcd_wr_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = (st_q.cnt == '0);
endmodule

// File: rtl/lcd_wr_seq_ctrl.sv
module lcd_wr_seq_ctrl
    import lcd_wr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  timing_t           cfg_in,
    input  logic              phase_done,
    output logic              tmr_load,
    output logic [TIME_W-1:0] tmr_val,
    output phase_e            phase_d_o,
    output phase_e            phase_q_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] data_q_o
);
    typedef struct packed {
        phase_e            phase;
        timing_t           cfg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_ADDR;
                    st_d.cfg   = cfg_in;
                    st_d.addr  = req_addr;
                    st_d.data  = req_data;
                    tmr_load   = 1'b1;
                    tmr_val    = cfg_in.addr_setup;
                end
            end
            PH_ADDR: begin
                if (phase_done) begin
                    st_d.phase = PH_CSSET;
                    tmr_load   = 1'b1;
                    tmr_val    = st_q.cfg.cs_to_we;
                end
            end
            PH_CSSET: begin
                if (phase_done) begin
                    st_d.phase = PH_STRB;
                    tmr_load   = 1'b1;
                    tmr_val    = st_q.cfg.we_width;
                end
            end
            PH_STRB: begin
                if (phase_done) begin
                    st_d.phase = PH_HOLD;
                    tmr_load   = 1'b1;
                    tmr_val    = st_q.cfg.we_to_cs;
                end
            end
            PH_HOLD: begin
                if (phase_done) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, cfg: '0, addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_d_o = st_d.phase;
    assign phase_q_o = st_q.phase;
    assign addr_q_o  = st_q.addr;
    assign data_q_o  = st_q.data;
endmodule

// File: rtl/lcd_wr_seq_pins.sv
module lcd_wr_seq_pins
    import lcd_wr_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_nxt,
    input  logic [DATA_W-1:0] wdata,
    output logic              cs_n,
    output logic              we_n,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              cs_n;
        logic              we_n;
        logic [DATA_W-1:0] data;
    } pin_t;

    pin_t st_d, st_q;

    always_comb begin
        st_d.cs_n = !(phase_nxt == PH_CSSET || phase_nxt == PH_STRB ||
                      phase_nxt == PH_HOLD);
        st_d.we_n = (phase_nxt != PH_STRB);
        st_d.data = (phase_nxt == PH_STRB || phase_nxt == PH_HOLD) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cs_n: 1'b1, we_n: 1'b1, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n = st_q.cs_n;
    assign we_n = st_q.we_n;
    assign data = st_q.data;
endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
    import lcd_wr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TIME_W-1:0] cfg_addr_setup,
    input  logic [TIME_W-1:0] cfg_cs_to_we,
    input  logic [TIME_W-1:0] cfg_we_width,
    input  logic [TIME_W-1:0] cfg_we_to_cs,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              busy
);
    timing_t           cfg_in;
    logic              phase_done;
    logic              tmr_load;
    logic [TIME_W-1:0] tmr_val;
    phase_e            phase_d;
    phase_e            phase_q;
    logic [DATA_W-1:0] data_q;

    assign cfg_in = '{addr_setup: cfg_addr_setup, cs_to_we: cfg_cs_to_we,
                      we_width: cfg_we_width, we_to_cs: cfg_we_to_cs};

    lcd_wr_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .cfg_in     (cfg_in),
        .phase_done (phase_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .phase_d_o  (phase_d),
        .phase_q_o  (phase_q),
        .addr_q_o   (bus_addr),
        .data_q_o   (data_q)
    );

    lcd_wr_seq_timer #(.CNT_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (phase_done)
    );

    lcd_wr_seq_pins #(.DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_d),
        .wdata     (data_q),
        .cs_n      (bus_cs_n),
        .we_n      (bus_we_n),
        .data      (bus_data)
    );

    assign req_ready = (phase_q == PH_IDLE);
    assign busy      = (phase_q != PH_IDLE);
endmodule

// File: rtl/lcd_wr_seq_chk.sv
module lcd_wr_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_we_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              busy
);
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> !bus_cs_n); // R8

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && busy)); // R2

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_addr)); // R3

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_data)); // R7

    AST_CS_RISE_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cs_n) |-> req_ready); // R6

    AST_WE_FALL_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_we_n) |-> $past(!bus_cs_n)); // R4

    AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> (bus_data == '0)); // R7
endmodule

bind lcd_wr_seq lcd_wr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_data  (bus_data),
    .busy      (busy)
);

// File: tb/sim_lcd_wr_seq.sv
`timescale 1ns/1ps
module sim_lcd_wr_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [3:0]    c_a = '0, c_s = '0, c_w = '0, c_h = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_cs_n, bus_we_n, busy;
    logic [DW-1:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lcd_wr_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .cfg_addr_setup(c_a), .cfg_cs_to_we(c_s), .cfg_we_width(c_w),
        .cfg_we_to_cs(c_h), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_we_n(bus_we_n), .bus_data(bus_data), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; optionally scramble settings after acceptance (R9).
    task automatic do_write(input int a, input int s, input int w, input int h,
                            input logic [AW-1:0] ad, input logic [DW-1:0] dt,
                            input bit scramble);
        int cs_fall = -1, we_fall = -1, we_rise = -1, cs_rise = -1;
        int rdy_at = -1;
        bit addr_ok = 1, data_ok = 1, idle_ok = 1;
        @(negedge clk);
        check("R10 ready before request", int'(req_ready), 1);
        c_a = 4'(a); c_s = 4'(s); c_w = 4'(w); c_h = 4'(h);
        req_addr = ad; req_data = dt; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~ad; req_data = ~dt;
        if (scramble) begin
            c_a = 4'(15 - a); c_s = 4'(15 - s); c_w = 4'(15 - w); c_h = 4'(15 - h);
        end
        check("R2 ready low after accept", int'(req_ready), 0);
        check("R2 busy after accept", int'(busy), 1);
        for (int i = 0; i < 80; i++) begin
            if (i > 0) @(negedge clk);
            if (!bus_cs_n && cs_fall < 0) cs_fall = i;
            if (!bus_we_n && we_fall < 0) we_fall = i;
            if (bus_we_n && we_fall >= 0 && we_rise < 0) we_rise = i;
            if (bus_cs_n && cs_fall >= 0 && cs_rise < 0) cs_rise = i;
            if (req_ready && rdy_at < 0) rdy_at = i;
            if (cs_rise < 0 && bus_addr != ad) addr_ok = 0;
            if (we_fall >= 0 && cs_rise < 0 && bus_data != dt) data_ok = 0;
            if ((we_fall < 0 || cs_rise >= 0) && bus_data != '0) idle_ok = 0;
            if (cs_rise >= 0) break;
        end
        check("R3 cs fall cycle", cs_fall, a + 1);
        check("R4 we fall cycle", we_fall, a + s + 2);
        check("R5 we rise cycle", we_rise, a + s + w + 3);
        check("R6 cs rise cycle", cs_rise, a + s + w + h + 4);
        check("R6 ready with cs rise", rdy_at, a + s + w + h + 4);
        check("R3 address steady", int'(addr_ok), 1);
        check("R7 data during strobe and hold", int'(data_ok), 1);
        check("R7 data zero outside", int'(idle_ok), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cs_n in reset", int'(bus_cs_n), 1);
        check("R1 we_n in reset", int'(bus_we_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 data after reset", int'(bus_data), 0);
        check("R1 cs_n after reset", int'(bus_cs_n), 1);
    endtask

    task automatic t_patterns();
        do_write(0, 0, 0, 0, 16'h1234, 16'hA5A5, 0);
        do_write(15, 15, 15, 15, 16'hFFFF, 16'h0001, 0);
        do_write(1, 2, 3, 4, 16'h0F0F, 16'h5A5A, 0);
        do_write(4, 3, 2, 1, 16'h8001, 16'hC3C3, 0);
    endtask

    task automatic t_sampled();
        do_write(2, 5, 1, 7, 16'h00AA, 16'h1357, 1); // R9
    endtask

    task automatic t_back_to_back();
        do_write(0, 1, 0, 2, 16'h0102, 16'h0304, 0); // R10
        do_write(3, 0, 2, 0, 16'h0506, 16'h0708, 0); // R10
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        c_a = 4'd1; c_s = 4'd1; c_w = 4'd8; c_h = 4'd1;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 strobe low mid write", int'(bus_we_n), 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 cs_n on mid reset", int'(bus_cs_n), 1);
        check("R1 we_n on mid reset", int'(bus_we_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after mid reset", int'(req_ready), 1);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_sampled();
        t_back_to_back();
        t_reset_mid();
        do_write(1, 1, 1, 1, 16'h4242, 16'h2424, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule